// File: doc/BRIEF.md
# Flow-Control Pause Frame Generator

This block sits beside a transmit MAC and decides when a flow-control frame has to go out. It takes a pause request for each traffic class. Each request can come from a hardware pin or from a register bit, and a register bit counts only when its enable is set. Any change in a class's effective request marks that class as pending. The block then asks the transmit arbiter for a slot with `tx_req_o` and waits for `tx_grant_i`, so a control frame never cuts into a client packet.

When the grant arrives, the block takes a snapshot of every pending class and streams one 60-byte frame, one byte per cycle, with no FCS. The frame holds the fixed multicast destination, a programmable source address, the MAC control type, an opcode and the pause times. A class whose request is high sends its programmed XOFF time. A class whose request has dropped sends zero, which is XON. With one class the block builds the classic single-time pause frame. With two to eight classes it builds the per-priority form, which carries a class vector.

Retransmission can be enabled. While a class's request stays high after its XOFF was sent, a hold-off counter counts down once per quantum tick. When the counter expires, the block raises a fresh XOFF for that class.

Top module: `pause_frame_gen`

## Requirements
- R1: The effective request of class k is `pin_req_i[k] | (reg_req_i[k] & reg_en_i[k])`. A register request bit whose enable is 0 raises no frame request. The enable does not gate the pins.
- R2: A change of a class's effective request sets the class pending. `tx_req_o` is high while any class is pending and no frame is being sent. No byte is emitted until `tx_grant_i` is sampled high together with `tx_req_o`.
- R3: The frame starts in the cycle after the grant. It is exactly 60 consecutive valid bytes, `frame_last_o` is high only on byte 59, and `frame_valid_o` falls right after that byte.
- R4: Bytes 0-5 are 01 80 C2 00 00 01. Bytes 6-11 are the source address with the most significant byte first: the two bytes of `src_addr_hi_i` and then the four bytes of `src_addr_lo_i`. Bytes 12-13 are 88 08. All bytes after the body are zero.
- R5: With NUM_CLASSES = 1, bytes 14-15 are 00 01 and bytes 16-17 hold the pause time, high byte first: `xoff_quanta_i` if the request is high, zero if it is low.
- R6: With NUM_CLASSES > 1, bytes 14-15 are 01 01 and bytes 16-17 hold a 16-bit class vector, high byte first, with bit k set when class k is in the frame. Bytes 18+2k and 19+2k hold the time for class k, high byte first: `xoff_quanta_i[16k+:16]` when the class is in the frame with its request high, and zero in every other case.
- R7: A request that falls produces a frame in which that class is present with a zero time (XON).
- R8: Every class that becomes pending before the grant goes out in one frame.
- R9: With `retx_en_i` = 1, sending an XOFF for a class whose request is still high loads `holdoff_i`. The count drops by one on each `quantum_tick_i` and never sets the class pending before it reaches zero. Once it has reached zero, the class becomes pending again. With `retx_en_i` = 0, one XOFF is sent per assertion.
- R10: Once a class's request has dropped and its XON has been sent, no further quantum ticks raise a request for it.
- R11: After reset, `tx_req_o`, `frame_valid_o` and `frame_last_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_req_i | input | NUM_CLASSES | Pause request pins, one per class |
| reg_req_i | input | NUM_CLASSES | Register pause request bits |
| reg_en_i | input | NUM_CLASSES | Enables for the register request bits |
| xoff_quanta_i | input | 16*NUM_CLASSES | XOFF pause time per class, class 0 in the low bits |
| holdoff_i | input | 16 | Retransmit hold-off, in quanta |
| retx_en_i | input | 1 | Retransmission enable |
| src_addr_lo_i | input | 32 | Source address bits 31:0 |
| src_addr_hi_i | input | 16 | Source address bits 47:32 |
| quantum_tick_i | input | 1 | One pulse per pause quantum |
| tx_req_o | output | 1 | Request for a control-frame slot |
| tx_grant_i | input | 1 | Slot grant from the transmit arbiter |
| frame_valid_o | output | 1 | Frame byte valid |
| frame_data_o | output | 8 | Frame byte |
| frame_last_o | output | 1 | Final byte of the frame |

## Verification
A request edge applied before a clock edge sets the class pending at that edge, so `tx_req_o` can be seen at the next sample point. The bench therefore samples on the falling edge and polls for the request before it grants. Byte 0 appears in the cycle after the grant edge, and one byte follows per cycle. The bench reads all 60 bytes on consecutive falling edges and compares them with a frame it builds itself from the class vector and request levels. The hold-off expiry is due one edge after the last needed tick and is visible one cycle later. The bench checks that `tx_req_o` stays low before that tick, then allows two cycles of margin after it before expecting the request.

// File: rtl/pause_gen_pkg.sv
package pause_gen_pkg;
  localparam int FRAME_BYTES = 60;
  localparam int QUANTA_W    = 16;
  localparam int MAX_CLASSES = 8;
  localparam int BODY_BYTES  = 2 + 2 * MAX_CLASSES;
  localparam int IDX_W       = $clog2(FRAME_BYTES);

  localparam logic [47:0] CTRL_DST_MAC = 48'h0180C2000001;
  localparam logic [15:0] CTRL_ETYPE   = 16'h8808;
  localparam logic [15:0] OPC_LINK     = 16'h0001;
  localparam logic [15:0] OPC_PRIO     = 16'h0101;

  typedef logic [FRAME_BYTES-1:0][7:0] frame_t;
endpackage

// File: rtl/pause_class_tracker.sv
module pause_class_tracker #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             grab_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] holdoff_i,
  input  logic             retx_en_i,
  output logic             pend_o,
  output logic             level_o
);
  logic             lvl_q, pend_q, arm_q;
  logic [CNT_W-1:0] cnt_q;
  logic             edge_ev, expire;

  assign edge_ev = req_i ^ lvl_q;
  assign expire  = arm_q & (cnt_q == '0) & lvl_q & retx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= req_i;
      pend_q <= (pend_q & ~grab_i) | edge_ev | expire;
    end
  end

  // hold-off: armed when an XOFF leaves, cancelled by a drop or disable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else if (grab_i && lvl_q && retx_en_i) begin
      arm_q <= 1'b1;
      cnt_q <= holdoff_i;
    end else if (expire || !lvl_q || !retx_en_i) begin
      arm_q <= 1'b0;
    end else if (arm_q && tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pend_o  = pend_q;
  assign level_o = lvl_q;

  // R9
  hold_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q && !tick_i && !grab_i) |=> $stable(cnt_q));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !lvl_q && !pend_q) |=> !pend_q);
endmodule

// File: rtl/pause_frame_builder.sv
module pause_frame_builder
  import pause_gen_pkg::*;
#(
  parameter int NUM_CLASSES = 8
) (
  input  logic [NUM_CLASSES-1:0]          class_vec_i,
  input  logic [NUM_CLASSES-1:0]          level_i,
  input  logic [NUM_CLASSES*QUANTA_W-1:0] quanta_i,
  input  logic [15:0]                     src_hi_i,
  input  logic [31:0]                     src_lo_i,
  output frame_t                          frame_o
);
  logic [BODY_BYTES-1:0][7:0] body;
  logic [15:0]                opcode;
  logic [47:0]                src;

  assign src = {src_hi_i, src_lo_i};

  if (NUM_CLASSES == 1) begin : g_link
    logic [15:0] q;
    assign opcode = OPC_LINK;
    assign q      = level_i[0] ? quanta_i[15:0] : 16'h0000;
    always_comb begin
      body    = '0;
      body[0] = q[15:8];
      body[1] = q[7:0];
    end
  end else begin : g_prio
    logic [15:0] vec16;
    assign opcode = OPC_PRIO;
    always_comb begin
      vec16                   = '0;
      vec16[NUM_CLASSES-1:0]  = class_vec_i;
      body                    = '0;
      body[0]                 = vec16[15:8];
      body[1]                 = vec16[7:0];
      for (int k = 0; k < NUM_CLASSES; k++) begin
        if (class_vec_i[k] && level_i[k]) begin
          body[2+2*k] = quanta_i[k*QUANTA_W+8 +: 8];
          body[3+2*k] = quanta_i[k*QUANTA_W   +: 8];
        end
      end
    end
  end

  always_comb begin
    frame_o = '0;
    for (int i = 0; i < 6; i++) begin
      frame_o[i]   = CTRL_DST_MAC[47-8*i -: 8];
      frame_o[6+i] = src[47-8*i -: 8];
    end
    frame_o[12] = CTRL_ETYPE[15:8];
    frame_o[13] = CTRL_ETYPE[7:0];
    frame_o[14] = opcode[15:8];
    frame_o[15] = opcode[7:0];
    for (int b = 0; b < BODY_BYTES; b++) frame_o[16+b] = body[b];
  end
endmodule

// File: rtl/pause_byte_streamer.sv
module pause_byte_streamer
  import pause_gen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  frame_t     frame_i,
  output logic       busy_o,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  frame_t           frame_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load_i && !busy_q) begin
      frame_q <= frame_i;
      idx_q   <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
      else                   idx_q  <= idx_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = busy_q;
  assign data_o  = frame_q[idx_q];
  assign last_o  = busy_q && (idx_q == LAST_IDX);

  // R3
  end_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !valid_o);

  // R3
  fall_on_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> $past(last_o));
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pause_gen_pkg::*;
#(
  parameter int NUM_CLASSES = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_CLASSES-1:0]          pin_req_i,
  input  logic [NUM_CLASSES-1:0]          reg_req_i,
  input  logic [NUM_CLASSES-1:0]          reg_en_i,
  input  logic [NUM_CLASSES*QUANTA_W-1:0] xoff_quanta_i,
  input  logic [QUANTA_W-1:0]             holdoff_i,
  input  logic                            retx_en_i,
  input  logic [31:0]                     src_addr_lo_i,
  input  logic [15:0]                     src_addr_hi_i,
  input  logic                            quantum_tick_i,
  output logic                            tx_req_o,
  input  logic                            tx_grant_i,
  output logic                            frame_valid_o,
  output logic [7:0]                      frame_data_o,
  output logic                            frame_last_o
);
  logic [NUM_CLASSES-1:0] eff_req, pend_vec, level_vec, grab_vec;
  logic                   busy, accept;
  frame_t                 frame_next;

  assign eff_req  = pin_req_i | (reg_req_i & reg_en_i);
  assign tx_req_o = !busy && (|pend_vec);
  assign accept   = tx_req_o && tx_grant_i;
  assign grab_vec = {NUM_CLASSES{accept}} & pend_vec;

  for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cls
    pause_class_tracker #(.CNT_W(QUANTA_W)) i_trk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (eff_req[k]),
      .grab_i    (grab_vec[k]),
      .tick_i    (quantum_tick_i),
      .holdoff_i (holdoff_i),
      .retx_en_i (retx_en_i),
      .pend_o    (pend_vec[k]),
      .level_o   (level_vec[k])
    );
  end

  pause_frame_builder #(.NUM_CLASSES(NUM_CLASSES)) i_build (
    .class_vec_i (pend_vec),
    .level_i     (level_vec),
    .quanta_i    (xoff_quanta_i),
    .src_hi_i    (src_addr_hi_i),
    .src_lo_i    (src_addr_lo_i),
    .frame_o     (frame_next)
  );

  pause_byte_streamer i_stream (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .frame_i (frame_next),
    .busy_o  (busy),
    .valid_o (frame_valid_o),
    .data_o  (frame_data_o),
    .last_o  (frame_last_o)
  );

  // R2
  no_req_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> !tx_req_o);

  // R3
  start_after_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && tx_grant_i) |=> (frame_valid_o && frame_data_o == 8'h01));

  // R2
  no_start_unasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_valid_o) |-> $past(tx_req_o && tx_grant_i));

  // R3
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_last_o |-> frame_valid_o);
endmodule

// File: tb/test_pause_frame_gen.sv
module test_pause_frame_gen;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [7:0]  pin_req, reg_req, reg_en;
  logic [127:0] quanta;
  logic [15:0] holdoff;
  logic        retx_en, tick, grant, sel_std, pin_std;
  logic        req_p, val_p, last_p, req_s, val_s, last_s;
  logic [7:0]  data_p, data_s;
  logic        tx_req, f_val, f_last;
  logic [7:0]  f_data;
  logic [7:0]  exp_b [60];
  int          errors = 0;
  int          checks = 0;

  localparam logic [15:0] SA_HI = 16'h0A1B;
  localparam logic [31:0] SA_LO = 32'h2C3D4E5F;
  localparam logic [15:0] Q_STD = 16'h1234;

  always #4 clk = ~clk;

  pause_frame_gen #(.NUM_CLASSES(8)) i_pause_frame_gen (
    .clk_i(clk), .rst_ni(rst_ni), .pin_req_i(pin_req), .reg_req_i(reg_req),
    .reg_en_i(reg_en), .xoff_quanta_i(quanta), .holdoff_i(holdoff),
    .retx_en_i(retx_en), .src_addr_lo_i(SA_LO), .src_addr_hi_i(SA_HI),
    .quantum_tick_i(tick), .tx_req_o(req_p), .tx_grant_i(grant & ~sel_std),
    .frame_valid_o(val_p), .frame_data_o(data_p), .frame_last_o(last_p));

  pause_frame_gen #(.NUM_CLASSES(1)) i_pause_frame_gen_std (
    .clk_i(clk), .rst_ni(rst_ni), .pin_req_i(pin_std), .reg_req_i(1'b0),
    .reg_en_i(1'b0), .xoff_quanta_i(Q_STD), .holdoff_i(holdoff),
    .retx_en_i(retx_en), .src_addr_lo_i(SA_LO), .src_addr_hi_i(SA_HI),
    .quantum_tick_i(tick), .tx_req_o(req_s), .tx_grant_i(grant & sel_std),
    .frame_valid_o(val_s), .frame_data_o(data_s), .frame_last_o(last_s));

  assign tx_req = sel_std ? req_s  : req_p;
  assign f_val  = sel_std ? val_s  : val_p;
  assign f_data = sel_std ? data_s : data_p;
  assign f_last = sel_std ? last_s : last_p;

  function automatic logic [15:0] q_of(input int k);
    return 16'hA000 | 16'(k << 4) | 16'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build_exp(input bit std, input logic [7:0] vec, input logic [7:0] lvl);
    logic [47:0] sa;
    logic [47:0] da;
    logic [15:0] q;
    sa = {SA_HI, SA_LO};
    da = 48'h0180C2000001;
    for (int i = 0; i < 60; i++) exp_b[i] = 8'h00;
    for (int i = 0; i < 6; i++) begin
      exp_b[i]   = da[47-8*i -: 8];
      exp_b[6+i] = sa[47-8*i -: 8];
    end
    exp_b[12] = 8'h88; exp_b[13] = 8'h08;
    if (std) begin
      exp_b[14] = 8'h00; exp_b[15] = 8'h01;
      q = lvl[0] ? Q_STD : 16'h0;
      exp_b[16] = q[15:8]; exp_b[17] = q[7:0];
    end else begin
      exp_b[14] = 8'h01; exp_b[15] = 8'h01;
      exp_b[16] = 8'h00; exp_b[17] = vec;
      for (int k = 0; k < 8; k++) begin
        q = (vec[k] && lvl[k]) ? q_of(k) : 16'h0;
        exp_b[18+2*k] = q[15:8]; exp_b[19+2*k] = q[7:0];
      end
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic idle_chk(input string req, input int cyc);
    bit seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (tx_req || f_val) seen = 1;
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic frame_chk(input string req, input bit std, input logic [7:0] vec, input logic [7:0] lvl);
    int w = 0;
    int bad = -1;
    bit last_bad = 0;
    bit val_bad = 0;
    logic [7:0] got = 0;
    build_exp(std, vec, lvl);
    while (!tx_req && w < 50) begin @(negedge clk); w++; end
    chk(tx_req, {req, " request raised"}, tx_req, 1);
    chk(!f_val, "R2 no byte before grant", f_val, 0);
    grant = 1'b1; @(negedge clk); grant = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (!f_val) val_bad = 1;
      if (f_last !== (i == 59)) last_bad = 1;
      if (f_data !== exp_b[i] && bad < 0) begin bad = i; got = f_data; end
      if (i < 59) @(negedge clk);
    end
    chk(!val_bad, "R3 60 valid bytes", val_bad, 0);
    chk(!last_bad, "R3 last on byte 59", last_bad, 0);
    chk(bad < 0, $sformatf("%s frame byte %0d", req, bad), got, (bad < 0) ? 0 : exp_b[bad]);
    @(negedge clk);
    chk(!f_val, "R3 valid ends after last", f_val, 0);
  endtask

  task automatic t_reset;
    chk(!req_p && !req_s, "R11 tx_req after reset", {req_p, req_s}, 0);
    chk(!val_p && !val_s && !last_p && !last_s, "R11 frame outputs after reset",
        {val_p, val_s, last_p, last_s}, 0);
  endtask

  task automatic t_reg_gate;
    reg_req[2] = 1'b1;
    idle_chk("R1 masked register request", 6);
    reg_en[2] = 1'b1;
    @(negedge clk);
    idle_chk("R2 waits without grant", 0);
    repeat (4) @(negedge clk);
    chk(tx_req && !f_val, "R2 request held while ungranted", {tx_req, f_val}, 2'b10);
    frame_chk("R6 R4 single class xoff", 0, 8'h04, 8'h04);
  endtask

  task automatic t_merge;
    pin_req[0] = 1'b1; pin_req[5] = 1'b1;
    @(negedge clk);
    pin_req[7] = 1'b1;
    repeat (2) @(negedge clk);
    frame_chk("R8 R1 merged classes", 0, 8'hA1, 8'hA5);
    ticks(5);
    idle_chk("R9 no retransmit when disabled", 4);
  endtask

  task automatic t_xon;
    pin_req[5] = 1'b0;
    frame_chk("R7 xon for one class", 0, 8'h20, 8'h85);
    reg_req[2] = 1'b0; pin_req[0] = 1'b0; pin_req[7] = 1'b0;
    @(negedge clk);
    frame_chk("R7 combined xon", 0, 8'h85, 8'h00);
    idle_chk("R2 idle after all sent", 4);
  endtask

  task automatic t_retx;
    retx_en = 1'b1; holdoff = 16'd3;
    pin_req[3] = 1'b1;
    frame_chk("R9 first xoff", 0, 8'h08, 8'h08);
    idle_chk("R9 hold before ticks", 10);
    ticks(2);
    idle_chk("R9 hold before count ends", 3);
    ticks(1);
    repeat (2) @(negedge clk);
    chk(tx_req, "R9 retransmit after hold-off", tx_req, 1);
    frame_chk("R9 repeated xoff", 0, 8'h08, 8'h08);
    pin_req[3] = 1'b0;
    frame_chk("R10 xon after drop", 0, 8'h08, 8'h00);
    ticks(6);
    idle_chk("R10 no retransmit after drop", 4);
  endtask

  task automatic t_std;
    sel_std = 1'b1;
    retx_en = 1'b0;
    pin_std = 1'b1;
    frame_chk("R5 link pause xoff", 1, 8'h01, 8'h01);
    pin_std = 1'b0;
    frame_chk("R5 link pause xon", 1, 8'h01, 8'h00);
    sel_std = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) quanta[k*16 +: 16] = q_of(k);
    rst_ni = 1'b0; pin_req = '0; reg_req = '0; reg_en = '0;
    holdoff = 16'd0; retx_en = 1'b0; tick = 1'b0; grant = 1'b0;
    sel_std = 1'b0; pin_std = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg_gate();
    t_merge();
    t_xon();
    t_retx();
    t_std();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule